// File: doc/BRIEF.md
# I2C Target Dual-Address Byte Buffer

This block is the data store behind an I2C target. A separate bus engine turns line activity into single-cycle events: an own address was matched (with the matched code and the transfer direction), a byte arrived from the controller, the controller wants the next byte, a stop was seen, a bus error occurred, or arbitration was lost. The block answers transmit requests with bytes from a prepared buffer, keeps received bytes in another buffer, and tracks the result of the transaction.

There are two own addresses, a primary one and a secondary one. Each has a transmit buffer, which the controller reads from, and a receive buffer, which the controller writes into. Every buffer holds `DEPTH` bytes (64 by default). The set is chosen when the address matches: a code equal to the configured primary address uses the primary set, and any other code uses the secondary set. The host side fills transmit buffers through a write port and commits them with a preload command. It reads received bytes through a read port and releases them with a drain command. A reset command returns both buffers of a set to empty. The host also collects a completion record once a stop has ended a transaction.

Top module: `i2c_tgt_dualbuf`

## Requirements
- R1: After reset, `done_ready`, `tx_valid` and `host_rsp_valid` are 0, `done_size` is 0, and every entry of all four buffers reads 0xFF on `host_rd_data`. Buffer number on `host_rd_buf` is {set, dir}, where set 0 is primary and dir 0 is transmit.
- R2: An address match whose code equals `cfg_primary_addr` selects the primary set (set 0). Any other code selects the secondary set (set 1). The selection holds until the next address match.
- R3: On an address match, the code and direction (`ev_addr_rd`=1 means the controller reads) are latched onto `done_addr`/`done_rd` and the result is cleared to 0. For a read, the first transmit byte appears on `tx_byte` with `tx_valid` one cycle after the event.
- R4: Each transmit request yields the byte at the current index of the selected transmit buffer one cycle later, and the index advances. A request after all stored bytes are used yields 0xFF and leaves the result unchanged.
- R5: A fetch from a transmit buffer whose size is 0 yields 0xFF and sets the result to zero-length (code 3).
- R6: A received byte is stored at the index of the selected receive buffer, and the index and size both advance by one. When `DEPTH` bytes are already stored, the byte is dropped and the result becomes overrun (code 4).
- R7: A preload command (`host_cmd`=0) longer than `DEPTH` answers overrun (code 4) and leaves the buffer unchanged. Otherwise it answers 0, sets the transmit size to the length and rewinds the index. The response appears one cycle after the command.
- R8: A drain command (`host_cmd`=1) whose length differs from the stored receive size answers buffer-size (code 5) and changes nothing. A matching length answers 0 and empties the receive buffer.
- R9: A reset command (`host_cmd`=2) empties both buffers of the named set and fills all their entries with 0xFF.
- R10: A bus error sets the result to code 1 and arbitration loss sets it to code 2. Only one bus event is taken per cycle, in this priority: bus error, arbitration loss, transmit request, received byte, stop, address match.
- R11: A stop sets `done_ready`, and `host_collect` clears it. A stop in the same cycle as a collect leaves it set.
- R12: `done_size` equals the current size of the buffer picked by the latched set and direction: the transmit buffer for a read, the receive buffer for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_primary_addr | input | ADDR_W | Primary own address code |
| ev_addr_valid | input | 1 | Own address matched |
| ev_addr_code | input | ADDR_W | Matched address code |
| ev_addr_rd | input | 1 | 1: controller reads, 0: controller writes |
| ev_rx_valid | input | 1 | Byte received from controller |
| ev_rx_byte | input | 8 | Received byte |
| ev_tx_req | input | 1 | Controller requests next byte |
| ev_stop | input | 1 | Stop condition seen |
| ev_bus_err | input | 1 | Bus error seen |
| ev_arb_lost | input | 1 | Arbitration lost |
| tx_valid | output | 1 | Byte supplied this cycle |
| tx_byte | output | 8 | Byte for the controller |
| host_wr_en | input | 1 | Write one transmit buffer entry |
| host_wr_set | input | 1 | Set of the written transmit buffer |
| host_wr_idx | input | IDX_W | Entry index |
| host_wr_data | input | 8 | Entry data |
| host_rd_buf | input | 2 | Buffer to read, {set, dir} |
| host_rd_idx | input | IDX_W | Entry to read |
| host_rd_data | output | 8 | Entry content |
| host_cmd_valid | input | 1 | Command strobe |
| host_cmd | input | 2 | 0 preload, 1 drain, 2 reset, 3 none |
| host_cmd_set | input | 1 | Set the command applies to |
| host_cmd_len | input | LEN_W | Length for preload or drain |
| host_rsp_valid | output | 1 | Command response valid |
| host_rsp_err | output | 3 | Command result code |
| host_collect | input | 1 | Host takes the completion record |
| done_ready | output | 1 | Completion record available |
| done_addr | output | ADDR_W | Latched address code |
| done_rd | output | 1 | Latched direction |
| done_size | output | CNT_W | Size of the latched buffer |
| done_err | output | 3 | Result code (0 none, 1 bus, 2 arbitration, 3 zero-length, 4 overrun, 5 buffer-size) |

## Verification
The hardest state to reach is the receive buffer that is exactly full. The controller must deliver `DEPTH` bytes without an intervening drain, and the next byte must then be dropped while the size stays put. The stimulus writes `DEPTH`+1 bytes to the primary address in a single transaction. The transmit side has a similar corner: a request past the stored size must give 0xFF with no error, while a request on an empty buffer must flag an error. Both are reached by preloading a short buffer on one address and leaving the other one empty. A behavioural model built from queues and integers tracks every buffer and is compared against all outputs on every cycle.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_BUS      = 3'd1,
    ERR_ARB      = 3'd2,
    ERR_ZERO_LEN = 3'd3,
    ERR_OVERRUN  = 3'd4,
    ERR_BUF_SIZE = 3'd5
  } tgt_err_e;

  typedef enum logic [2:0] {
    BOP_IDLE,
    BOP_CLEAR,
    BOP_PUSH,
    BOP_POP,
    BOP_LOAD,
    BOP_DRAIN
  } buf_op_e;

  typedef enum logic [1:0] {
    HCMD_PRELOAD = 2'd0,
    HCMD_DRAIN   = 2'd1,
    HCMD_RESET   = 2'd2,
    HCMD_NOP     = 2'd3
  } host_cmd_e;

  // a stored byte is still available for the controller
  function automatic bit pop_in_range(int unsigned size, int unsigned idx);
    return (size != 0) && (idx < size);
  endfunction

  // one more received byte fits
  function automatic bit push_fits(int unsigned idx, int unsigned depth);
    return idx < depth;
  endfunction

  // host preload length acceptable
  function automatic bit load_fits(int unsigned len, int unsigned depth);
    return len <= depth;
  endfunction

endpackage

// File: rtl/i2c_tgt_buf.sv
module i2c_tgt_buf
  import i2c_tgt_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  buf_op_e          op,
  input  logic [CNT_W-1:0] op_len,
  input  logic [7:0]       op_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic [7:0]       head_data,
  output logic [CNT_W-1:0] size,
  output logic [CNT_W-1:0] index
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [7:0] mem [DEPTH];
  logic       push_take;
  logic       pop_take;

  assign push_take = (op == BOP_PUSH) && push_fits(int'(index), DEPTH);
  assign pop_take  = (op == BOP_POP) && pop_in_range(int'(size), int'(index));

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[e] <= 8'hFF;
      end else if (op == BOP_CLEAR) begin
        mem[e] <= 8'hFF;
      end else if (push_take && (index[IDX_W-1:0] == IDX_W'(e))) begin
        mem[e] <= op_data;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        mem[e] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size  <= '0;
      index <= '0;
    end else begin
      unique case (op)
        BOP_CLEAR, BOP_DRAIN: begin
          size  <= '0;
          index <= '0;
        end
        BOP_PUSH: if (push_take) begin
          index <= index + CNT_W'(1);
          size  <= index + CNT_W'(1);
        end
        BOP_POP: if (pop_take) index <= index + CNT_W'(1);
        BOP_LOAD: begin
          size  <= op_len;
          index <= '0;
        end
        default: ;
      endcase
    end
  end

  assign head_data = (index < DEPTH_C) ? mem[index[IDX_W-1:0]] : 8'hFF;
  assign rd_data   = mem[rd_idx];

  p_push_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_take |=> size == $past(index) + CNT_W'(1));
  p_full_push_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == BOP_PUSH && !push_take) |=> ($stable(size) && $stable(index)));
  p_index_le_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
    index <= size);
  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == BOP_CLEAR) |=> (size == '0 && index == '0));

endmodule

// File: rtl/i2c_tgt_seq.sv
module i2c_tgt_seq
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DEPTH  = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_primary_addr,
  input  logic              ev_addr_valid,
  input  logic [ADDR_W-1:0] ev_addr_code,
  input  logic              ev_addr_rd,
  input  logic              ev_rx_valid,
  input  logic              ev_tx_req,
  input  logic              ev_stop,
  input  logic              ev_bus_err,
  input  logic              ev_arb_lost,
  input  logic              host_collect,
  input  logic [CNT_W-1:0]  tx_size,
  input  logic [CNT_W-1:0]  tx_index,
  input  logic [7:0]        tx_head,
  input  logic [CNT_W-1:0]  rx_index,
  output logic              sel_now,
  output buf_op_e           tx_op,
  output buf_op_e           rx_op,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic              done_ready,
  output logic [ADDR_W-1:0] done_addr,
  output logic              done_rd,
  output logic              done_sel,
  output tgt_err_e          done_err
);

  logic     quiet_hi;
  logic     take_arb, take_tx, take_rx, take_stop, take_addr;
  logic     fetch, fetch_zero, fetch_hit, rx_full;
  logic [7:0] fetch_byte;
  tgt_err_e next_err;

  assign quiet_hi  = !ev_bus_err && !ev_arb_lost;
  assign take_arb  = ev_arb_lost && !ev_bus_err;
  assign take_tx   = quiet_hi && ev_tx_req;
  assign take_rx   = quiet_hi && !ev_tx_req && ev_rx_valid;
  assign take_stop = quiet_hi && !ev_tx_req && !ev_rx_valid && ev_stop;
  assign take_addr = quiet_hi && !ev_tx_req && !ev_rx_valid && !ev_stop && ev_addr_valid;

  assign sel_now    = take_addr ? (ev_addr_code != cfg_primary_addr) : done_sel;
  assign fetch      = take_tx || (take_addr && ev_addr_rd);
  assign fetch_zero = (tx_size == '0);
  assign fetch_hit  = pop_in_range(int'(tx_size), int'(tx_index));
  assign fetch_byte = fetch_hit ? tx_head : 8'hFF;
  assign rx_full    = !push_fits(int'(rx_index), DEPTH);

  assign tx_op = fetch   ? BOP_POP  : BOP_IDLE;
  assign rx_op = take_rx ? BOP_PUSH : BOP_IDLE;

  always_comb begin
    next_err = done_err;
    if (ev_bus_err)                next_err = ERR_BUS;
    else if (take_arb)             next_err = ERR_ARB;
    else if (fetch && fetch_zero)  next_err = ERR_ZERO_LEN;
    else if (take_rx && rx_full)   next_err = ERR_OVERRUN;
    else if (take_addr)            next_err = ERR_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid   <= 1'b0;
      tx_byte    <= 8'hFF;
      done_ready <= 1'b0;
      done_addr  <= '0;
      done_rd    <= 1'b0;
      done_sel   <= 1'b0;
      done_err   <= ERR_NONE;
    end else begin
      tx_valid <= fetch;
      if (fetch) tx_byte <= fetch_byte;
      if (take_stop)         done_ready <= 1'b1;
      else if (host_collect) done_ready <= 1'b0;
      if (take_addr) begin
        done_addr <= ev_addr_code;
        done_rd   <= ev_addr_rd;
        done_sel  <= sel_now;
      end
      done_err <= next_err;
    end
  end

  p_stop_sets_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take_stop |=> done_ready);
  p_collect_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_collect && !take_stop) |=> !done_ready);
  p_fetch_answers_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> tx_valid);
  p_overrun_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_tx && !fetch_zero && !fetch_hit) |=> (tx_byte == 8'hFF && $stable(done_err)));
  p_zero_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && fetch_zero) |=> (done_err == ERR_ZERO_LEN && tx_byte == 8'hFF));
  p_addr_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_addr && !ev_addr_rd) |=> (done_err == ERR_NONE));
  p_bus_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_err |=> (done_err == ERR_BUS && !tx_valid));

endmodule

// File: rtl/i2c_tgt_host.sv
module i2c_tgt_host
  import i2c_tgt_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LEN_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [CNT_W-1:0] rx_size,
  output buf_op_e          tx_op,
  output buf_op_e          rx_op,
  output logic [CNT_W-1:0] op_len,
  output logic             rsp_valid,
  output tgt_err_e         rsp_err
);

  host_cmd_e kind;
  logic      is_load, is_drain, is_reset;
  logic      load_ok, drain_ok;
  tgt_err_e  verdict;

  assign kind     = host_cmd_e'(cmd);
  assign is_load  = cmd_valid && (kind == HCMD_PRELOAD);
  assign is_drain = cmd_valid && (kind == HCMD_DRAIN);
  assign is_reset = cmd_valid && (kind == HCMD_RESET);
  assign load_ok  = load_fits(int'(cmd_len), DEPTH);
  assign drain_ok = (cmd_len == LEN_W'(rx_size));
  assign op_len   = CNT_W'(cmd_len);

  always_comb begin
    tx_op = BOP_IDLE;
    rx_op = BOP_IDLE;
    if (is_reset) begin
      tx_op = BOP_CLEAR;
      rx_op = BOP_CLEAR;
    end else if (is_load && load_ok) begin
      tx_op = BOP_LOAD;
    end else if (is_drain && drain_ok) begin
      rx_op = BOP_DRAIN;
    end
  end

  always_comb begin
    verdict = ERR_NONE;
    if (is_load && !load_ok)        verdict = ERR_OVERRUN;
    else if (is_drain && !drain_ok) verdict = ERR_BUF_SIZE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= ERR_NONE;
    end else begin
      rsp_valid <= cmd_valid;
      if (cmd_valid) rsp_err <= verdict;
    end
  end

  p_preload_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && !load_ok) |=> (rsp_valid && rsp_err == ERR_OVERRUN));
  p_drain_mismatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_drain && !drain_ok) |=> (rsp_valid && rsp_err == ERR_BUF_SIZE));
  p_rsp_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);

endmodule

// File: rtl/i2c_tgt_dualbuf.sv
module i2c_tgt_dualbuf
  import i2c_tgt_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 7,
  parameter int LEN_W  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_primary_addr,
  input  logic              ev_addr_valid,
  input  logic [ADDR_W-1:0] ev_addr_code,
  input  logic              ev_addr_rd,
  input  logic              ev_rx_valid,
  input  logic [7:0]        ev_rx_byte,
  input  logic              ev_tx_req,
  input  logic              ev_stop,
  input  logic              ev_bus_err,
  input  logic              ev_arb_lost,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              host_wr_en,
  input  logic              host_wr_set,
  input  logic [IDX_W-1:0]  host_wr_idx,
  input  logic [7:0]        host_wr_data,
  input  logic [1:0]        host_rd_buf,
  input  logic [IDX_W-1:0]  host_rd_idx,
  output logic [7:0]        host_rd_data,
  input  logic              host_cmd_valid,
  input  logic [1:0]        host_cmd,
  input  logic              host_cmd_set,
  input  logic [LEN_W-1:0]  host_cmd_len,
  output logic              host_rsp_valid,
  output logic [2:0]        host_rsp_err,
  input  logic              host_collect,
  output logic              done_ready,
  output logic [ADDR_W-1:0] done_addr,
  output logic              done_rd,
  output logic [CNT_W-1:0]  done_size,
  output logic [2:0]        done_err
);

  localparam int NBUF = 4;

  logic [CNT_W-1:0] size_arr  [NBUF];
  logic [CNT_W-1:0] index_arr [NBUF];
  logic [7:0]       head_arr  [NBUF];
  logic [7:0]       rd_arr    [NBUF];

  logic             sel_now, done_sel;
  buf_op_e          seq_tx_op, seq_rx_op, host_tx_op, host_rx_op;
  logic [CNT_W-1:0] host_len;
  tgt_err_e         seq_err, host_err;

  i2c_tgt_seq #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_seq (
    .clk, .rst_n, .cfg_primary_addr,
    .ev_addr_valid, .ev_addr_code, .ev_addr_rd, .ev_rx_valid,
    .ev_tx_req, .ev_stop, .ev_bus_err, .ev_arb_lost, .host_collect,
    .tx_size  (size_arr[{sel_now, 1'b0}]),
    .tx_index (index_arr[{sel_now, 1'b0}]),
    .tx_head  (head_arr[{sel_now, 1'b0}]),
    .rx_index (index_arr[{sel_now, 1'b1}]),
    .sel_now, .tx_op(seq_tx_op), .rx_op(seq_rx_op),
    .tx_valid, .tx_byte, .done_ready, .done_addr, .done_rd, .done_sel,
    .done_err (seq_err)
  );

  i2c_tgt_host #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_host (
    .clk, .rst_n,
    .cmd_valid (host_cmd_valid),
    .cmd       (host_cmd),
    .cmd_len   (host_cmd_len),
    .rx_size   (size_arr[{host_cmd_set, 1'b1}]),
    .tx_op     (host_tx_op),
    .rx_op     (host_rx_op),
    .op_len    (host_len),
    .rsp_valid (host_rsp_valid),
    .rsp_err   (host_err)
  );

  // buffer b = {set, dir}; dir 0 transmit, dir 1 receive
  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    localparam bit SET = b[1];
    localparam bit DIR = b[0];
    buf_op_e bus_op, host_op, op;
    logic    bus_hit;

    assign bus_op  = DIR ? seq_rx_op : seq_tx_op;
    assign host_op = DIR ? host_rx_op : host_tx_op;
    assign bus_hit = (sel_now == SET) && (bus_op != BOP_IDLE);
    assign op      = bus_hit ? bus_op : ((host_cmd_set == SET) ? host_op : BOP_IDLE);

    i2c_tgt_buf #(.DEPTH(DEPTH)) u_buf (
      .clk, .rst_n,
      .op        (op),
      .op_len    (host_len),
      .op_data   (ev_rx_byte),
      .wr_en     (host_wr_en && !DIR && (host_wr_set == SET)),
      .wr_idx    (host_wr_idx),
      .wr_data   (host_wr_data),
      .rd_idx    (host_rd_idx),
      .rd_data   (rd_arr[b]),
      .head_data (head_arr[b]),
      .size      (size_arr[b]),
      .index     (index_arr[b])
    );
  end

  assign host_rd_data = rd_arr[host_rd_buf];
  assign done_size    = size_arr[{done_sel, ~done_rd}];
  assign done_err     = seq_err;
  assign host_rsp_err = host_err;

  p_select_primary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_addr_valid && !ev_bus_err && !ev_arb_lost && !ev_tx_req && !ev_rx_valid && !ev_stop
     && ev_addr_code == cfg_primary_addr) |=> !done_sel);
  p_size_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_size <= CNT_W'(DEPTH));

endmodule

// File: tb/test_i2c_tgt_dualbuf.sv
module test_i2c_tgt_dualbuf;

  localparam int DEPTH = 64;
  localparam logic [6:0] PRIM = 7'h2A;
  localparam logic [6:0] SECA = 7'h33;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [6:0] cfg_primary_addr = PRIM;
  logic ev_addr_valid = 0, ev_addr_rd = 0, ev_rx_valid = 0, ev_tx_req = 0;
  logic ev_stop = 0, ev_bus_err = 0, ev_arb_lost = 0;
  logic [6:0] ev_addr_code = '0;
  logic [7:0] ev_rx_byte = '0;
  logic host_wr_en = 0, host_wr_set = 0, host_cmd_valid = 0, host_cmd_set = 0, host_collect = 0;
  logic [5:0] host_wr_idx = '0, host_rd_idx = '0;
  logic [7:0] host_wr_data = '0, host_cmd_len = '0;
  logic [1:0] host_rd_buf = '0, host_cmd = 2'd3;
  logic tx_valid, done_ready, done_rd, host_rsp_valid;
  logic [7:0] tx_byte, host_rd_data;
  logic [6:0] done_addr, done_size;
  logic [2:0] done_err, host_rsp_err;

  i2c_tgt_dualbuf i_i2c_tgt_dualbuf (.*);

  int checks = 0, failures = 0;
  bit finished = 0;

  // behavioural reference
  int ms[4], mi[4];
  int mm[4][$];
  int m_res = 0, m_ready = 0, m_addr = 0, m_rd = 0, m_sel = 0;
  int m_txv = 0, m_txb = 0, m_rspv = 0, m_rspe = 0;

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic mclear(int b);
    ms[b] = 0; mi[b] = 0;
    for (int k = 0; k < DEPTH; k++) mm[b][k] = 8'hFF;
  endtask

  task automatic mpop(int b);
    m_txv = 1;
    if (ms[b] == 0) begin m_res = 3; m_txb = 8'hFF; end
    else if (mi[b] < ms[b]) begin m_txb = mm[b][mi[b]]; mi[b]++; end
    else m_txb = 8'hFF;
  endtask

  task automatic model_step();
    int hb;
    m_txv = 0; m_rspv = 0;
    if (host_collect) m_ready = 0;
    if (ev_bus_err) m_res = 1;
    else if (ev_arb_lost) m_res = 2;
    else if (ev_tx_req) mpop(m_sel * 2);
    else if (ev_rx_valid) begin
      hb = m_sel * 2 + 1;
      if (mi[hb] < DEPTH) begin mm[hb][mi[hb]] = ev_rx_byte; mi[hb]++; ms[hb] = mi[hb]; end
      else m_res = 4;
    end else if (ev_stop) m_ready = 1;
    else if (ev_addr_valid) begin
      m_sel = (ev_addr_code != cfg_primary_addr) ? 1 : 0;
      m_addr = ev_addr_code; m_rd = ev_addr_rd; m_res = 0;
      if (ev_addr_rd) mpop(m_sel * 2);
    end
    if (host_wr_en && !(host_cmd_valid && host_cmd == 2 && host_cmd_set == host_wr_set))
      mm[host_wr_set * 2][host_wr_idx] = host_wr_data;
    if (host_cmd_valid) begin
      hb = host_cmd_set * 2;
      m_rspv = 1; m_rspe = 0;
      case (host_cmd)
        2'd0: if (host_cmd_len > DEPTH) m_rspe = 4; else begin ms[hb] = host_cmd_len; mi[hb] = 0; end
        2'd1: if (host_cmd_len != ms[hb + 1]) m_rspe = 5; else begin ms[hb + 1] = 0; mi[hb + 1] = 0; end
        2'd2: begin mclear(hb); mclear(hb + 1); end
        default: ;
      endcase
    end
  endtask

  task automatic compare_all();
    chk("R11", done_ready, m_ready, "done_ready");
    chk("R10", done_err, m_res, "done_err");
    chk("R3", done_addr, m_addr, "done_addr");
    chk("R3", done_rd, m_rd, "done_rd");
    chk("R12", done_size, ms[m_sel * 2 + (m_rd ? 0 : 1)], "done_size");
    chk("R4", tx_valid, m_txv, "tx_valid");
    if (m_txv) chk("R4", tx_byte, m_txb, "tx_byte");
    chk("R7", host_rsp_valid, m_rspv, "rsp_valid");
    if (m_rspv) chk("R8", host_rsp_err, m_rspe, "rsp_err");
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    ev_addr_valid = 0; ev_rx_valid = 0; ev_tx_req = 0; ev_stop = 0;
    ev_bus_err = 0; ev_arb_lost = 0; host_wr_en = 0; host_cmd_valid = 0; host_collect = 0;
  endtask

  task automatic do_addr(logic [6:0] code, logic rd);
    ev_addr_valid = 1; ev_addr_code = code; ev_addr_rd = rd; cyc();
  endtask
  task automatic do_tx(); ev_tx_req = 1; cyc(); endtask
  task automatic do_rx(logic [7:0] d); ev_rx_valid = 1; ev_rx_byte = d; cyc(); endtask
  task automatic do_stop(); ev_stop = 1; cyc(); endtask
  task automatic do_collect(); host_collect = 1; cyc(); endtask
  task automatic do_cmd(logic [1:0] c, logic s, logic [7:0] len);
    host_cmd_valid = 1; host_cmd = c; host_cmd_set = s; host_cmd_len = len; cyc();
  endtask
  task automatic do_wr(logic s, logic [5:0] idx, logic [7:0] d);
    host_wr_en = 1; host_wr_set = s; host_wr_idx = idx; host_wr_data = d; cyc();
  endtask
  task automatic peek(string tag, logic [1:0] b, logic [5:0] idx);
    host_rd_buf = b; host_rd_idx = idx; #1;
    chk(tag, host_rd_data, mm[b][idx], "host_rd_data");
  endtask

  initial begin
    for (int b = 0; b < 4; b++) mclear(b);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", done_ready, 0, "ready in reset");
    chk("R1", tx_valid, 0, "tx_valid in reset");
    chk("R1", host_rsp_valid, 0, "rsp_valid in reset");
    chk("R1", done_size, 0, "size in reset");
    peek("R1", 2'd0, 6'd0);
    peek("R1", 2'd3, 6'd63);
    rst_n = 1;
    cyc();

    // R7 preload primary with four bytes, then an oversize preload
    for (int k = 0; k < 4; k++) do_wr(1'b0, 6'(k), 8'h10 + 8'(k));
    do_cmd(2'd0, 1'b0, 8'd4);
    chk("R7", host_rsp_err, 0, "preload ok");
    do_cmd(2'd0, 1'b0, 8'd65);
    chk("R7", host_rsp_err, 4, "preload too long");
    // secondary preload with other data
    do_wr(1'b1, 6'd0, 8'hA5);
    do_cmd(2'd0, 1'b1, 8'd1);

    // R2 R3 R4 primary read
    do_addr(PRIM, 1'b1);
    chk("R3", tx_byte, 8'h10, "prefetch byte");
    chk("R2", done_size, 4, "primary tx size");
    for (int k = 1; k < 4; k++) begin
      do_tx();
      chk("R4", tx_byte, 8'h10 + k, "next byte");
    end
    do_tx();
    chk("R4", tx_byte, 8'hFF, "past end filler");
    chk("R4", done_err, 0, "past end no error");
    do_stop();
    chk("R11", done_ready, 1, "ready after stop");
    do_collect();
    chk("R11", done_ready, 0, "collect clears");

    // R2 secondary read gets its own data
    do_addr(SECA, 1'b1);
    chk("R2", tx_byte, 8'hA5, "secondary data");
    do_stop();
    // R5 empty buffer: reset secondary then read
    do_cmd(2'd2, 1'b1, 8'd0);
    do_addr(SECA, 1'b1);
    chk("R5", tx_byte, 8'hFF, "zero-length filler");
    chk("R5", done_err, 3, "zero-length error");
    do_tx();
    chk("R5", done_err, 3, "zero-length again");
    // R11 stop and collect in one cycle
    ev_stop = 1; host_collect = 1; cyc();
    chk("R11", done_ready, 1, "stop wins over collect");
    do_collect();

    // R6 R8 R12 secondary write
    do_addr(SECA, 1'b0);
    chk("R3", done_err, 0, "result cleared");
    do_rx(8'h5C); do_rx(8'h6D); do_rx(8'h7E);
    chk("R12", done_size, 3, "rx size");
    do_stop(); do_collect();
    peek("R6", 2'd3, 6'd1);
    chk("R6", host_rd_data, 8'h6D, "stored byte");
    do_cmd(2'd1, 1'b1, 8'd2);
    chk("R8", host_rsp_err, 5, "drain mismatch");
    chk("R8", done_size, 3, "drain mismatch keeps size");
    do_cmd(2'd1, 1'b1, 8'd3);
    chk("R8", host_rsp_err, 0, "drain ok");
    chk("R8", done_size, 0, "drain empties");

    // R6 primary write overrun
    do_addr(PRIM, 1'b0);
    for (int k = 0; k < DEPTH; k++) do_rx(8'(k + 1));
    chk("R6", done_size, DEPTH, "full");
    chk("R6", done_err, 0, "full no error");
    do_rx(8'hEE);
    chk("R6", done_err, 4, "overrun");
    chk("R6", done_size, DEPTH, "overrun size held");
    peek("R6", 2'd1, 6'd63);

    // R10 error events and priority
    ev_bus_err = 1; ev_rx_valid = 1; ev_rx_byte = 8'h11; cyc();
    chk("R10", done_err, 1, "bus error");
    ev_arb_lost = 1; ev_stop = 1; cyc();
    chk("R10", done_err, 2, "arbitration lost");
    chk("R10", done_ready, 0, "stop dropped under arbitration loss");
    do_stop(); do_collect();

    // R9 reset primary set
    do_cmd(2'd2, 1'b0, 8'd0);
    chk("R9", done_size, 0, "reset size");
    peek("R9", 2'd1, 6'd5);
    peek("R9", 2'd0, 6'd2);
    chk("R9", host_rd_data, 8'hFF, "reset fill");
    do_addr(PRIM, 1'b1);
    chk("R9", done_err, 3, "reset tx empty");
    do_stop(); do_collect();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule